// File: doc/BRIEF.md
# Character Display Bus Command Sequencer

This block drives a character display controller over an 8-bit parallel bus with a register-select line, a read/write line and an enable strobe. A client hands it one request at a time through a valid/ready handshake. A request can place the cursor at a row and column, write one character byte at the current position, or load one pixel row of a custom glyph. The block turns each request into bus cycles. It reads the controller's busy flag before every cycle, and it issues nothing until that flag reads clear.

To write a string, the client sends one character request per byte after a single cursor request. The controller advances its own address after every data write, so no further address cycles are needed. Row and column positions follow the two-line layout. Row 0 starts at address 00h and row 1 starts at address 40h. The address counter value returned by every busy poll is kept on an output. A position outside the grid is refused at once with an error pulse. A controller that stays busy too long ends the request with a timeout pulse.

Top module: `chardisp_host_seq`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `lcd_e` stays low while `req_ready` is high.
- R2: Every write bus cycle (`lcd_rw`=0) comes after a busy read whose returned bit 7 was 0, with no other write in between.
- R3: A busy read drives `lcd_rs`=0 and `lcd_rw`=1, and holds `lcd_d_oe` low for the whole strobe.
- R4: A cursor request (`req_kind`=0) produces one busy read and then one write with `lcd_rs`=0 and data byte 80h + address. The address is `req_col` for row 0 and 40h + `req_col` for row 1.
- R5: A cursor request with `req_row` > 1 or `req_col` >= 40, and any request with `req_kind`=3, is refused. `req_error` pulses in the accepting cycle, no bus cycle takes place, and the block stays ready.
- R6: A character request (`req_kind`=1) produces one busy read and then one write with `lcd_rs`=1 carrying `req_data`. It produces no address cycle, and the data bus is driven while the strobe is high.
- R7: A glyph request (`req_kind`=2) produces four bus cycles in this order: a busy read, a write with `lcd_rs`=0 and byte 40h + `req_glyph_addr`, a second busy read, and a write with `lcd_rs`=1 carrying `req_data`.
- R8: In every bus cycle, `lcd_rs`, `lcd_rw`, `lcd_d_out` and `lcd_d_oe` are steady for at least SETUP_CYC cycles before `lcd_e` rises and stay steady while it is high. `lcd_e` is high for exactly PULSE_CYC cycles, and the signals do not change for at least HOLD_CYC cycles after it falls.
- R9: If MAX_POLLS busy reads in a row all return bit 7 = 1, `poll_timeout` pulses, the block returns to ready, and it issues no write for that request.
- R10: `ac_value` holds bits 6..0 of the byte returned by the most recent busy read.
- R11: After reset, `lcd_e`=0, `lcd_d_oe`=0, `req_ready`=1, `req_error`=0 and `poll_timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_kind | input | 2 | 0 cursor move, 1 character byte, 2 glyph row, 3 reserved |
| req_row | input | ROW_W | Cursor row |
| req_col | input | COL_W | Cursor column |
| req_glyph_addr | input | 6 | Glyph memory address for a glyph row request |
| req_data | input | 8 | Character byte or glyph row pattern |
| lcd_rs | output | 1 | Register select: 0 instruction/status, 1 data |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_e | output | 1 | Enable strobe |
| lcd_d_out | output | 8 | Bus value when driving |
| lcd_d_oe | output | 1 | Bus output enable |
| lcd_d_in | input | 8 | Bus value from the display |
| ac_value | output | 7 | Last captured address counter |
| req_error | output | 1 | One-cycle pulse when a request is refused |
| poll_timeout | output | 1 | One-cycle pulse when the busy limit is reached |

## Verification
The bench builds the block with SETUP_CYC=1, PULSE_CYC=2, HOLD_CYC=1 and MAX_POLLS=4. Short strobes keep each cursor request to a few dozen cycles, so all 256 row/column combinations of the 2-bit row and 6-bit column inputs can be swept, valid and refused alike. A poll limit of four lets a display model that stays busy for ten polls exhaust the limit, while two busy polls show the retry path that ends in a write. The model tracks its own address counter, so the captured value can be predicted after a cursor move followed by a string of characters.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  typedef enum logic [1:0] {
    KIND_CURSOR = 2'd0,
    KIND_CHAR   = 2'd1,
    KIND_GLYPH  = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_t;

  // Instruction byte that points the controller at a text position.
  function automatic logic [7:0] pos_cmd(input logic [6:0] addr);
    return {1'b1, addr};
  endfunction

  // Instruction byte that points the controller at glyph memory.
  function automatic logic [7:0] glyph_cmd(input logic [5:0] addr);
    return {2'b01, addr};
  endfunction

endpackage

// File: rtl/chardisp_addr_map.sv
module chardisp_addr_map #(
  parameter int ROW_W = 2,
  parameter int COL_W = 6,
  parameter int COLS  = 40
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             ok,
  output logic [6:0]       addr
);
  localparam logic [6:0] LINE1_BASE = 7'h40;

  always_comb begin
    ok   = (row < ROW_W'(2)) && (int'(col) < COLS);
    addr = (row[0] ? LINE1_BASE : 7'h00) + 7'(col);
  end
endmodule

// File: rtl/chardisp_bus_cycle.sv
module chardisp_bus_cycle #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rs_in,
  input  logic       rw_in,
  input  logic [7:0] wdata,
  output logic       done,
  output logic [7:0] rdata,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_d_out,
  output logic       lcd_d_oe,
  input  logic [7:0] lcd_d_in
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_t;
  phase_t         phase;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      rdata     <= 8'h00;
      lcd_rs    <= 1'b0;
      lcd_rw    <= 1'b1;
      lcd_e     <= 1'b0;
      lcd_d_out <= 8'h00;
      lcd_d_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          lcd_rs    <= rs_in;
          lcd_rw    <= rw_in;
          lcd_d_out <= wdata;
          lcd_d_oe  <= !rw_in;
          cnt       <= CW'(SETUP_CYC - 1);
          phase     <= PH_SETUP;
        end
        PH_SETUP: if (cnt == '0) begin
          lcd_e <= 1'b1;
          cnt   <= CW'(PULSE_CYC - 1);
          phase <= PH_PULSE;
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin
          lcd_e <= 1'b0;
          rdata <= lcd_d_in;
          cnt   <= CW'(HOLD_CYC - 1);
          phase <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/chardisp_host_seq.sv
module chardisp_host_seq
  import chardisp_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12,
  parameter int HOLD_CYC  = 2,
  parameter int MAX_POLLS = 1000,
  parameter int ROW_W     = 2,
  parameter int COL_W     = 6,
  parameter int COLS      = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [5:0]       req_glyph_addr,
  input  logic [7:0]       req_data,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e,
  output logic [7:0]       lcd_d_out,
  output logic             lcd_d_oe,
  input  logic [7:0]       lcd_d_in,
  output logic [6:0]       ac_value,
  output logic             req_error,
  output logic             poll_timeout
);
  localparam int PCW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_POLL_W, S_OP, S_OP_W} st_t;
  st_t st;

  logic       map_ok;
  logic [6:0] map_addr;
  chardisp_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W), .COLS(COLS)) u_map (
    .row(req_row), .col(req_col), .ok(map_ok), .addr(map_addr)
  );

  req_kind_t      kind_in, kind_q;
  logic [7:0]     data_q, instr_q;
  logic           second_q;
  logic [PCW-1:0] poll_cnt;
  logic           reject, op_is_data;
  logic           bc_start, bc_rs, bc_rw, bc_done;
  logic [7:0]     bc_wdata, bc_rdata;

  always_comb begin
    kind_in    = req_kind_t'(req_kind);
    reject     = (kind_in == KIND_RSVD) || ((kind_in == KIND_CURSOR) && !map_ok);
    op_is_data = second_q || (kind_q == KIND_CHAR);
    bc_start   = (st == S_POLL) || (st == S_OP);
    bc_rw      = (st == S_POLL);
    bc_rs      = (st == S_OP) && op_is_data;
    bc_wdata   = (st != S_OP) ? 8'h00 : (op_is_data ? data_q : instr_q);
  end

  assign req_ready = (st == S_IDLE);

  chardisp_bus_cycle #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_bus (
    .clk(clk), .rst(rst), .start(bc_start), .rs_in(bc_rs), .rw_in(bc_rw),
    .wdata(bc_wdata), .done(bc_done), .rdata(bc_rdata),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      kind_q       <= KIND_CHAR;
      data_q       <= 8'h00;
      instr_q      <= 8'h00;
      second_q     <= 1'b0;
      poll_cnt     <= '0;
      ac_value     <= 7'h00;
      req_error    <= 1'b0;
      poll_timeout <= 1'b0;
    end else begin
      req_error    <= 1'b0;
      poll_timeout <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (reject) req_error <= 1'b1;
          else begin
            kind_q   <= kind_in;
            data_q   <= req_data;
            instr_q  <= (kind_in == KIND_CURSOR) ? pos_cmd(map_addr) : glyph_cmd(req_glyph_addr);
            second_q <= 1'b0;
            poll_cnt <= '0;
            st       <= S_POLL;
          end
        end
        S_POLL: st <= S_POLL_W;
        S_POLL_W: if (bc_done) begin
          ac_value <= bc_rdata[6:0];
          if (!bc_rdata[7]) begin
            poll_cnt <= '0;
            st       <= S_OP;
          end else if (poll_cnt == PCW'(MAX_POLLS - 1)) begin
            poll_timeout <= 1'b1;
            st           <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            st       <= S_POLL;
          end
        end
        S_OP: st <= S_OP_W;
        default: if (bc_done) begin
          if ((kind_q == KIND_GLYPH) && !second_q) begin
            second_q <= 1'b1;
            st       <= S_POLL;
          end else st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/chardisp_host_seq_chk.sv
module chardisp_host_seq_chk #(
  parameter int PULSE_CYC = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [7:0] lcd_d_out,
  input logic       lcd_d_oe,
  input logic [7:0] lcd_d_in,
  input logic       req_error,
  input logic       poll_timeout
);
  logic        e_q, rw_q, busy_q, gate_ok;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_q     <= 1'b0;
      rw_q    <= 1'b0;
      busy_q  <= 1'b1;
      gate_ok <= 1'b0;
      hi_cnt  <= '0;
    end else begin
      e_q    <= lcd_e;
      rw_q   <= lcd_rw;
      busy_q <= lcd_d_in[7];
      hi_cnt <= lcd_e ? hi_cnt + 1'b1 : '0;
      if (e_q && !lcd_e && rw_q && !busy_q) gate_ok <= 1'b1;
      else if (!e_q && lcd_e && !lcd_rw)    gate_ok <= 1'b0;
    end
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst) req_ready |-> !lcd_e); // R1
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst) (!e_q && lcd_e && !lcd_rw) |-> gate_ok); // R2
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst) (lcd_e && lcd_rw) |-> !lcd_d_oe); // R3
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst) req_error |-> (req_ready && !lcd_e)); // R5
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst) (lcd_e && !lcd_rw) |-> lcd_d_oe); // R6
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (lcd_e && $past(lcd_e)) |-> $stable({lcd_rs, lcd_rw, lcd_d_out, lcd_d_oe})); // R8
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_e) |-> (hi_cnt == 16'(PULSE_CYC))); // R8
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst) poll_timeout |-> (req_ready && !lcd_e)); // R9
endmodule

bind chardisp_host_seq chardisp_host_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
  .lcd_e(lcd_e), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in),
  .req_error(req_error), .poll_timeout(poll_timeout)
);

// File: tb/tb_chardisp_host_seq.sv
`timescale 1ns/1ps
module tb_chardisp_host_seq;
  localparam int SETUP = 1, PULSE = 2, HOLD = 1, MAXP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = 2'd0, req_row = 2'd0;
  logic [5:0] req_col = 6'd0, req_glyph_addr = 6'd0;
  logic [7:0] req_data = 8'h00;
  logic lcd_rs, lcd_rw, lcd_e, lcd_d_oe, req_error, poll_timeout;
  logic [7:0] lcd_d_out, lcd_d_in;
  logic [6:0] ac_value;

  always #2 clk = ~clk;

  chardisp_host_seq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_row(req_row), .req_col(req_col), .req_glyph_addr(req_glyph_addr), .req_data(req_data),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe),
    .lcd_d_in(lcd_d_in), .ac_value(ac_value), .req_error(req_error), .poll_timeout(poll_timeout)
  );

  int checks = 0, failures = 0;

  // Display model and bus monitor
  int   busy_cfg = 0, busy_left = 0, ev_n = 0, tim_bad = 0, ungated = 0;
  int   hi = 0, stable_cnt = 100, fall_age = 100;
  logic [6:0] ac_model = 7'h00;
  logic e_prev = 1'b0, last_read_ok = 1'b0;
  logic [10:0] sig_prev = '0;
  logic ev_rs [0:1023];
  logic ev_rw [0:1023];
  logic [7:0] ev_d [0:1023];

  assign lcd_d_in = {(busy_left != 0) && (busy_cfg != 0), ac_model};

  always @(negedge clk) begin
    logic [10:0] sig;
    sig = {lcd_rs, lcd_rw, lcd_d_out, lcd_d_oe};
    if (sig != sig_prev) begin
      if (fall_age < HOLD) tim_bad++;
      stable_cnt = 0;
    end else if (stable_cnt < 100) stable_cnt++;
    if (lcd_e && !e_prev) begin
      if (stable_cnt < SETUP) tim_bad++;
      hi = 0;
    end
    if (lcd_e) hi++;
    if (!lcd_e && e_prev) begin
      if (hi != PULSE) tim_bad++;
      fall_age = 0;
      ev_rs[ev_n] = lcd_rs;
      ev_rw[ev_n] = lcd_rw;
      ev_d[ev_n]  = lcd_rw ? lcd_d_in : lcd_d_out;
      if (ev_n < 1023) ev_n++;
      if (lcd_rw) begin
        last_read_ok = !lcd_d_in[7];
        if (busy_left > 0) busy_left--;
      end else begin
        if (!last_read_ok) ungated++;
        last_read_ok = 1'b0;
        if (!lcd_rs && lcd_d_out[7])            ac_model = lcd_d_out[6:0];
        else if (!lcd_rs && lcd_d_out[7:6] == 2'b01) ac_model = {1'b0, lcd_d_out[5:0]};
        else                                      ac_model = ac_model + 7'd1;
        busy_left = busy_cfg;
      end
    end else if (fall_age < 100) fall_age++;
    if (busy_cfg == 0) busy_left = 0;
    e_prev   = lcd_e;
    sig_prev = sig;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Request driver; returns event base, refusal and timeout flags
  int   base;
  logic got_err, got_to, went_busy;
  task automatic send(input logic [1:0] k, input logic [1:0] r, input logic [5:0] c,
                      input logic [5:0] g, input logic [7:0] d);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base = ev_n;
    req_kind = k; req_row = r; req_col = c; req_glyph_addr = g; req_data = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_err = req_error;
    went_busy = !req_ready;
    got_to = 1'b0;
    n = 0;
    while (!req_ready && n < 2000) begin
      @(negedge clk);
      n++;
      if (poll_timeout) got_to = 1'b1;
    end
    if (n >= 2000) chk(1'b0, "R1 request never completed", n, 0);
  endtask

  function automatic bit ev_is(input int i, input logic rs, input logic rw, input logic [7:0] d);
    return (ev_rs[i] == rs) && (ev_rw[i] == rw) && (rw || ev_d[i] == d);
  endfunction

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!lcd_e && !lcd_d_oe && req_ready && !req_error && !poll_timeout, "R11 reset outputs",
        {lcd_e, lcd_d_oe, req_ready, req_error, poll_timeout}, 5'b00100);

    // R4 / R5 sweep of every row and column code
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 64; c++) begin
        bit valid;
        int exp_a;
        valid = (r < 2) && (c < 40);
        exp_a = 'h80 + (r % 2) * 'h40 + c;
        send(2'd0, 2'(r), 6'(c), 6'd0, 8'h00);
        if (valid)
          chk(!got_err && went_busy && (ev_n - base == 2) && ev_is(base, 0, 1, 0) &&
              ev_is(base + 1, 0, 0, 8'(exp_a)), "R4 cursor encoding", ev_d[base + 1], exp_a);
        else
          chk(got_err && (ev_n == base) && req_ready, "R5 refused position", ev_n - base, 0);
      end
    end
    // R1 the block goes not-ready while working
    send(2'd0, 2'd1, 6'd3, 6'd0, 8'h00);
    chk(went_busy, "R1 ready drops after acceptance", went_busy, 1);
    // R5 reserved kind
    send(2'd3, 2'd0, 6'd0, 6'd0, 8'h41);
    chk(got_err && ev_n == base, "R5 reserved kind refused", ev_n - base, 0);

    // R6 string after one cursor move
    send(2'd0, 2'd1, 6'd5, 6'd0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      send(2'd1, 2'd0, 6'd0, 6'd0, 8'(8'h41 + i));
      chk((ev_n - base == 2) && ev_is(base, 0, 1, 0) && ev_is(base + 1, 1, 0, 8'(8'h41 + i)),
          "R6 character write", ev_d[base + 1], 8'h41 + i);
    end
    // R10 address counter seen by the next poll: 40h + 5 + 3
    send(2'd0, 2'd0, 6'd0, 6'd0, 8'h00);
    chk(ev_d[base][6:0] == 7'h48 && ac_value == 7'h48, "R10 captured address counter", ac_value, 'h48);

    // R7 glyph row
    send(2'd2, 2'd0, 6'd0, 6'h2A, 8'h15);
    chk((ev_n - base == 4) && ev_is(base, 0, 1, 0) && ev_is(base + 1, 0, 0, 8'h6A) &&
        ev_is(base + 2, 0, 1, 0) && ev_is(base + 3, 1, 0, 8'h15), "R7 glyph sequence", ev_n - base, 4);
    chk(ac_value == 7'h2A, "R10 counter after glyph address", ac_value, 'h2A);

    // R2 busy twice, then clear
    busy_cfg = 2;
    send(2'd1, 2'd0, 6'd0, 6'd0, 8'h30);
    send(2'd1, 2'd0, 6'd0, 6'd0, 8'h5A);
    chk((ev_n - base == 4) && ev_d[base][7] && ev_d[base + 1][7] && !ev_d[base + 2][7] &&
        ev_is(base + 3, 1, 0, 8'h5A) && !got_to, "R2 write waits for clear flag", ev_n - base, 4);

    // R9 controller stuck busy
    busy_cfg = 10;
    send(2'd1, 2'd0, 6'd0, 6'd0, 8'h31);
    send(2'd1, 2'd0, 6'd0, 6'd0, 8'h51);
    chk(got_to && (ev_n - base == MAXP) && ev_rw[base + MAXP - 1] && req_ready,
        "R9 poll limit timeout", ev_n - base, MAXP);
    busy_cfg = 0;
    send(2'd1, 2'd0, 6'd0, 6'd0, 8'h52);
    chk(!got_to && (ev_n - base == 2) && ev_is(base + 1, 1, 0, 8'h52), "R9 recovery after timeout",
        ev_n - base, 2);

    // R2 / R3 / R8 whole-run bus observations
    chk(ungated == 0, "R2 no ungated write", ungated, 0);
    chk(tim_bad == 0, "R8 strobe timing", tim_bad, 0);
    begin
      int bad_reads = 0;
      for (int i = 0; i < ev_n; i++) if (ev_rw[i] && ev_rs[i]) bad_reads++;
      chk(bad_reads == 0, "R3 busy reads use instruction register", bad_reads, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule